// File: doc/BRIEF.md
# Round-Robin Stream Event Builder

This block gathers one event from a set of up to twelve stream FIFOs. It puts a 4-bit stream address on its port and checks the enable status that the addressed FIFO returns. Disabled streams are passed over. For each enabled stream, the block reads words until a word arrives with its end marker set. Every accepted 9-bit word is widened to a 16-bit output word that carries the stream number. The word is then written into the current output page. The first data word goes at page offset 4, and each later word goes at the next offset. After the scan leaves the last stream, four header words are written at offsets 0 to 3. Word 0 holds the total word count. Word 1 is zero. Words 2 and 3 hold the low and high halves of a 32-bit event counter. A one-cycle `evt_done` pulse then reports that the page is complete.

The controller is a four-state machine.
- `ST_IDLE`: the address is held at 0 and the machine waits for a start.
- `ST_SCAN`: the machine tests whether the addressed stream is enabled.
- `ST_READ`: the read strobe is high and the machine waits for data-available.
- `ST_HDR`: the four header words are written.

The transitions are as follows.
- *start*: `ST_IDLE` to `ST_SCAN`. It needs the readout enable to be high. In sample-all mode it also needs a free page.
- *hit*: `ST_SCAN` to `ST_READ`, when the addressed stream is enabled.
- *skip*: the machine stays in `ST_SCAN` and the address goes up by one.
- *empty pass*: `ST_SCAN` to `ST_IDLE`, when the address reaches 11 and no stream has supplied data.
- *close*: `ST_SCAN` to `ST_HDR` at address 11, once data has been seen.
- *next*: `ST_READ` to `ST_SCAN` on an end-marked word before stream 11.
- *last*: `ST_READ` to `ST_HDR` on an end-marked word from stream 11.
- *finish*: `ST_HDR` to `ST_IDLE` after header word 3.

Outside sample-all mode, the free-page flag is sampled only at *start*. If no page is free, the event is still read from the streams and still counted. However, nothing is written for it and no done pulse is given.

Top module: `ebld_event_builder`

## Requirements
- R1: After reset, `strm_rd`, `out_we` and `evt_done` are 0 and `strm_addr` is 0.
- R2: While `rdo_en` is low in the idle state, no stream is read and nothing is written.
- R3: An address whose `strm_on` is low is skipped at once. Only addresses 0 to 11 are issued. Each event's scan starts at 0 and ends after 11.
- R4: A word is taken only in a cycle where `strm_rd` and `strm_dav` are both high. Each such word is written exactly once, and gaps in `strm_dav` lose no word and add no word.
- R5: Reading from an enabled stream goes on until a word with bit 8 set has been taken. The address then advances. Stream events appear in ascending address order.
- R6: A data word is laid out as bits 15:13 = 0, bits 12:9 = stream address, bit 8 = end marker and bits 7:0 = stream data. Data words go at page offsets 4, 5, 6 and so on.
- R7: The header sits at offsets 0 to 3. Offset 0 holds the word count, header included, in bits 13:0, with bits 15:14 zero. Offset 1 is 0. Offsets 2 and 3 hold bits 15:0 and 31:16 of the number of events read since reset, and this count includes the current event.
- R8: In sample-all mode (`sample_all` = 1), no stream is read while `page_free` is low at the start of an event.
- R9: With `sample_all` = 0 and `page_free` low at the start of an event, the event's words are still taken from the streams. Nothing is written and `evt_done` does not pulse.
- R10: A pass in which no stream is enabled produces no write and no `evt_done`.
- R11: `evt_done` is a single-cycle pulse. It comes in the same cycle as the write of header offset 3, once per written event.
- R12: An enabled stream that has no data holds the builder on that address, with `strm_rd` high, for as long as it takes. The builder resumes correctly when data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdo_en | input | 1 | Readout enable, checked at the start of each event |
| sample_all | input | 1 | 1: wait for a free page before starting an event |
| page_free | input | 1 | The output buffer has a free page |
| strm_on | input | 1 | The addressed stream is enabled |
| strm_dav | input | 1 | The addressed stream presents a valid word this cycle |
| strm_data | input | 9 | Stream word; bit 8 is the end-of-stream-event marker |
| strm_rd | output | 1 | Read request to the addressed stream |
| strm_addr | output | 4 | Address of the stream being visited |
| out_we | output | 1 | Write strobe into the current output page |
| out_addr | output | 14 | Word offset within the page |
| out_word | output | 16 | Word to write |
| evt_done | output | 1 | Pulse: a complete event sits in the page |

## Verification
The stream FIFOs are modelled in the bench. A table of vectors drives this model with several enable masks:
- all twelve streams;
- stream 0 alone;
- stream 11 alone;
- a sparse mask;
- a mask with no streams.

These masks separate the skip path from the read path, and the close from `ST_SCAN` from the close from `ST_READ`. The vectors also vary the words per stream event, with and without gaps in data-available, to show that words are neither lost nor repeated. Directed cases hold back the readout enable, hold back the free page in each of the two modes, and starve one enabled stream. A run of two back-to-back events checks the event counter and the restart at address 0.

// File: rtl/ebld_pkg.sv
package ebld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_READ,
        ST_HDR
    } ebld_state_e;

    localparam int HDR_WORDS = 4;

endpackage

// File: rtl/ebld_cursor.sv
module ebld_cursor #(
    parameter int NSTREAM = 12,
    parameter int AW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    localparam logic [AW-1:0] LAST = AW'(NSTREAM - 1);

    assign at_last = (addr == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr <= '0;
        end else if (step) begin
            addr <= at_last ? '0 : addr + 1'b1;
        end
    end

    p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST);

    p_step_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !at_last) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/ebld_wordfmt.sv
module ebld_wordfmt #(
    parameter int AW  = 4,
    parameter int DW  = 9,
    parameter int OW  = 16,
    parameter int CW  = 14,
    parameter int HIW = 2
) (
    input  logic            sel_hdr,
    input  logic [HIW-1:0]  hdr_idx,
    input  logic [AW-1:0]   stream_id,
    input  logic [DW-1:0]   data,
    input  logic [CW-1:0]   wcount,
    input  logic [2*OW-1:0] evcount,
    output logic [OW-1:0]   word
);
    localparam int PAD = OW - AW - DW;

    always_comb begin
        if (!sel_hdr) begin
            word = {{PAD{1'b0}}, stream_id, data};
        end else if (hdr_idx == HIW'(0)) begin
            word = OW'(wcount);
        end else if (hdr_idx == HIW'(1)) begin
            word = '0;
        end else if (hdr_idx == HIW'(2)) begin
            word = evcount[OW-1:0];
        end else begin
            word = evcount[2*OW-1:OW];
        end
    end

endmodule

// File: rtl/ebld_event_builder.sv
module ebld_event_builder
    import ebld_pkg::*;
#(
    parameter int NSTREAM = 12,
    parameter int AW      = 4,
    parameter int DW      = 9,
    parameter int OW      = 16,
    parameter int CW      = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rdo_en,
    input  logic          sample_all,
    input  logic          page_free,
    input  logic          strm_on,
    input  logic          strm_dav,
    input  logic [DW-1:0] strm_data,
    output logic          strm_rd,
    output logic [AW-1:0] strm_addr,
    output logic          out_we,
    output logic [CW-1:0] out_addr,
    output logic [OW-1:0] out_word,
    output logic          evt_done
);
    localparam int HW  = HDR_WORDS;
    localparam int HIW = $clog2(HW);
    localparam int ECW = 2 * OW;

    ebld_state_e      state, nxt;
    logic [AW-1:0]    addr;
    logic             at_last, cur_clear, cur_step;
    logic             accept, eos, sel_hdr;
    logic             keep_r, any_r;
    logic [CW-1:0]    wc_r;
    logic [ECW-1:0]   ev_r;
    logic [HIW-1:0]   hidx_r;
    logic [OW-1:0]    fmt_word;

    assign accept    = (state == ST_READ) && strm_dav;
    assign eos       = strm_data[DW-1];
    assign sel_hdr   = (state == ST_HDR);
    assign strm_rd   = (state == ST_READ);
    assign strm_addr = addr;

    // transition logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (rdo_en && (!sample_all || page_free)) nxt = ST_SCAN;
            ST_SCAN: begin
                if (strm_on)      nxt = ST_READ;
                else if (at_last) nxt = any_r ? ST_HDR : ST_IDLE;
            end
            ST_READ: if (accept && eos) nxt = at_last ? ST_HDR : ST_SCAN;
            ST_HDR:  if (hidx_r == HIW'(HW - 1)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign cur_clear = (state == ST_IDLE);
    assign cur_step  = ((state == ST_SCAN) && !strm_on && !at_last)
                     || (accept && eos && !at_last);

    ebld_cursor #(.NSTREAM(NSTREAM), .AW(AW)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cur_clear),
        .step    (cur_step),
        .addr    (addr),
        .at_last (at_last)
    );

    ebld_wordfmt #(.AW(AW), .DW(DW), .OW(OW), .CW(CW), .HIW(HIW)) u_fmt (
        .sel_hdr   (sel_hdr),
        .hdr_idx   (hidx_r),
        .stream_id (addr),
        .data      (strm_data),
        .wcount    (wc_r),
        .evcount   (ev_r),
        .word      (fmt_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // counters and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_r   <= 1'b0;
            any_r    <= 1'b0;
            wc_r     <= '0;
            ev_r     <= '0;
            hidx_r   <= '0;
            out_we   <= 1'b0;
            out_addr <= '0;
            out_word <= '0;
            evt_done <= 1'b0;
        end else begin
            out_we   <= 1'b0;
            evt_done <= 1'b0;
            if ((state == ST_IDLE) && (nxt == ST_SCAN)) begin
                keep_r <= page_free;
                any_r  <= 1'b0;
                wc_r   <= CW'(HW);
            end
            if (accept) begin
                any_r    <= 1'b1;
                wc_r     <= wc_r + 1'b1;
                out_we   <= keep_r;
                out_addr <= wc_r;
                out_word <= fmt_word;
            end
            if ((nxt == ST_HDR) && (state != ST_HDR)) begin
                ev_r   <= ev_r + 1'b1;
                hidx_r <= '0;
            end
            if (state == ST_HDR) begin
                out_we   <= keep_r;
                out_addr <= CW'(hidx_r);
                out_word <= fmt_word;
                hidx_r   <= hidx_r + 1'b1;
                evt_done <= keep_r && (hidx_r == HIW'(HW - 1));
            end
        end
    end

    p_idle_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !rdo_en) |=> !strm_rd);

    p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_rd && !(strm_dav && strm_data[DW-1])) |=> $stable(strm_addr));

    p_data_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && (out_addr >= CW'(HW))) |-> (out_word[OW-1:AW+DW] == '0));

    p_wait_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && sample_all && !page_free) |=> !strm_rd);

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done);

    p_done_with_last_hdr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> (out_we && (out_addr == CW'(HW - 1))));

endmodule

// File: tb/test_ebld_event_builder.sv
module test_ebld_event_builder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdo_en = 1'b0;
    logic        sample_all = 1'b1;
    logic        page_free = 1'b1;
    logic        strm_on;
    logic        strm_dav;
    logic [8:0]  strm_data;
    logic        strm_rd;
    logic [3:0]  strm_addr;
    logic        out_we;
    logic [13:0] out_addr;
    logic [15:0] out_word;
    logic        evt_done;

    always #4 clk = ~clk;

    ebld_event_builder i_ebld_event_builder (
        .clk(clk), .rst_n(rst_n), .rdo_en(rdo_en), .sample_all(sample_all),
        .page_free(page_free), .strm_on(strm_on), .strm_dav(strm_dav),
        .strm_data(strm_data), .strm_rd(strm_rd), .strm_addr(strm_addr),
        .out_we(out_we), .out_addr(out_addr), .out_word(out_word),
        .evt_done(evt_done)
    );

    // stream FIFO model
    logic [11:0] mask = '0;
    int          nw = 1;
    logic        gap = 1'b0;
    int          avail [12];
    int          rptr [12];
    logic        tick = 1'b0;
    logic        load_req = 1'b0;
    logic [15:0] cap [128];
    int          n_done = 0, n_rd = 0, n_we = 0;

    always_comb begin
        strm_on   = 1'b0;
        strm_dav  = 1'b0;
        strm_data = '0;
        if (strm_addr < 4'd12) begin
            strm_on   = mask[strm_addr];
            strm_dav  = (rptr[strm_addr] < avail[strm_addr]) && (!gap || tick);
            strm_data = {((rptr[strm_addr] % nw) == nw - 1),
                         8'(int'(strm_addr) * 16 + rptr[strm_addr])};
        end
    end

    always @(posedge clk) begin
        tick <= ~tick;
        if (load_req) begin
            for (int s = 0; s < 12; s++) rptr[s] <= 0;
            n_done <= 0; n_rd <= 0; n_we <= 0;
        end else begin
            if (strm_rd && strm_dav) begin
                rptr[strm_addr] <= rptr[strm_addr] + 1;
                n_rd <= n_rd + 1;
            end
            if (out_we) begin
                cap[out_addr[6:0]] <= out_word;
                n_we <= n_we + 1;
            end
            if (evt_done) n_done <= n_done + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [11:0] m, input int words, input int events);
        mask = m; nw = words;
        for (int s = 0; s < 12; s++) avail[s] = m[s] ? words * events : 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rdo_en = 1'b0; rst_n = 1'b0; load_req = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; load_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done(input int want, input int limit);
        for (int i = 0; i < limit && n_done < want; i++) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int popc(input logic [11:0] m);
        int c = 0;
        for (int s = 0; s < 12; s++) c += int'(m[s]);
        return c;
    endfunction

    // compare a captured page against event number evn (0 = first since reset)
    task automatic check_page(input int evn, input string tag);
        int pos = 4, bad = 0, first_act = 0, first_exp = 0;
        logic [15:0] e;
        for (int s = 0; s < 12; s++) begin
            if (mask[s]) begin
                for (int k = 0; k < nw; k++) begin
                    e = {3'b000, 4'(s), (k == nw - 1), 8'(s * 16 + evn * nw + k)};
                    if (cap[pos] !== e) begin
                        if (bad == 0) begin first_act = int'(cap[pos]); first_exp = int'(e); end
                        bad++;
                    end
                    pos++;
                end
            end
        end
        chk(bad == 0, "R6/R5", {tag, " data words"}, first_act, first_exp);
        chk(cap[0] == 16'(pos), "R7", {tag, " word count"}, int'(cap[0]), pos);
        chk(cap[1] == 16'd0, "R7", {tag, " header word 1"}, int'(cap[1]), 0);
        chk(cap[2] == 16'(evn + 1), "R7", {tag, " event count low"}, int'(cap[2]), evn + 1);
        chk(cap[3] == 16'd0, "R7", {tag, " event count high"}, int'(cap[3]), 0);
    endtask

    // {mask[18:7], words[6:3], gap[2], sample_all[1], page_free[0]}
    localparam int NV = 7;
    localparam logic [18:0] VEC [NV] = '{
        {12'hFFF, 4'd1, 1'b0, 1'b1, 1'b1},
        {12'h001, 4'd3, 1'b1, 1'b1, 1'b1},
        {12'h800, 4'd2, 1'b0, 1'b1, 1'b1},
        {12'hA5A, 4'd4, 1'b1, 1'b0, 1'b1},
        {12'h000, 4'd2, 1'b0, 1'b1, 1'b1},
        {12'h0F0, 4'd2, 1'b0, 1'b0, 1'b0},
        {12'h3C3, 4'd5, 1'b1, 1'b1, 1'b1}
    };

    initial begin
        for (int s = 0; s < 12; s++) begin avail[s] = 0; rptr[s] = 0; end
        // R1: reset state
        do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        chk(!strm_rd && !out_we && !evt_done && strm_addr == 4'd0, "R1",
            "outputs in reset", int'({strm_rd, out_we, evt_done, strm_addr}), 0);
        rst_n = 1'b1;

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [11:0] m;
            int  words, tot;
            bit  expd;
            string tag;
            m = VEC[v][18:7];
            words = int'(VEC[v][6:3]);
            tot = popc(m) * words;
            expd = (m != 12'h000) && VEC[v][0];
            tag = $sformatf("vec%0d", v);
            do_reset();
            load(m, words, 1);
            gap = VEC[v][2]; sample_all = VEC[v][1]; page_free = VEC[v][0];
            rdo_en = 1'b1;
            if (expd) wait_done(1, 400);
            else repeat (150) @(negedge clk);
            chk(n_done == int'(expd), expd ? "R11" : (m == 0 ? "R10" : "R9"),
                {tag, " done pulses"}, n_done, int'(expd));
            chk(n_rd == tot, "R4", {tag, " words taken"}, n_rd, tot);
            chk(n_we == (expd ? tot + 4 : 0), expd ? "R4" : (m == 0 ? "R10" : "R9"),
                {tag, " words written"}, n_we, expd ? tot + 4 : 0);
            if (expd) check_page(0, tag);
            rdo_en = 1'b0;
        end
        gap = 1'b0; sample_all = 1'b1; page_free = 1'b1;

        // R2: readout enable held low
        do_reset();
        load(12'h104, 2, 1);
        repeat (50) @(negedge clk);
        chk(n_rd == 0 && !strm_rd, "R2", "reads while disabled", n_rd, 0);
        rdo_en = 1'b1;
        wait_done(1, 300);
        chk(n_done == 1, "R2", "event after enable", n_done, 1);

        // R8: sample-all waits for a page
        do_reset();
        load(12'h00C, 3, 1);
        page_free = 1'b0; rdo_en = 1'b1;
        repeat (50) @(negedge clk);
        chk(n_rd == 0, "R8", "reads with no free page", n_rd, 0);
        page_free = 1'b1;
        wait_done(1, 300);
        chk(n_done == 1 && n_rd == 6, "R8", "event after page frees", n_rd, 6);
        check_page(0, "R8");

        // R12: starved enabled stream
        do_reset();
        load(12'h006, 2, 1);
        avail[2] = 0;
        rdo_en = 1'b1;
        repeat (100) @(negedge clk);
        chk(n_done == 0 && n_rd == 2, "R12", "stalled reads", n_rd, 2);
        chk(strm_rd && strm_addr == 4'd2, "R12", "held on stream 2",
            int'(strm_addr), 2);
        avail[2] = 2;
        wait_done(1, 300);
        chk(n_done == 1, "R12", "resumed after data", n_done, 1);
        check_page(0, "R12");

        // R3/R7: two back-to-back events, counter and restart at 0
        do_reset();
        load(12'h021, 2, 2);
        rdo_en = 1'b1;
        wait_done(1, 300);
        chk(cap[2] == 16'd1, "R7", "first event count", int'(cap[2]), 1);
        wait_done(2, 300);
        chk(n_done == 2 && n_rd == 8, "R3", "second scan reads", n_rd, 8);
        check_page(1, "R3 second event");
        rdo_en = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule